// File: doc/BRIEF.md
# Rotating-Slot Inter-Core Mailbox

This block lets any of the cores of a multicore controller post a 32-bit word to any core, including itself. It has no datapath of its own. A free-running rotation counter decides which sender is connected to which receiver in each cycle. This is the same rotation that grants each core its time slot on the shared-memory crossbar. A message waits in its sender until that rotation connects the sender to the chosen receiver. It then takes that cycle, and the block flags the slot so the shared-memory access planned for it is dropped.

Each sender holds at most one pending message. The sender offers a write with a destination index, a data word and an interrupt flag. If it offers a new write while one is still pending, the write is held off and is not lost. Each receiver keeps the latest word from every source in its own register, plus a bitmask that marks which sources have delivered something not yet read. A receiver reads a word by naming the source. Asserting the read strobe clears that source's mark. The receiver's interrupt stays high while any marked source asked for one.

Top module: `slot_mailbox`

## Requirements
- R1: `rot_phase` is 0 while the internal reset is held. After that it advances by one every clock and wraps from N_CORES-1 to 0.
- R2: A write (`wr_req[s]` high while `wr_busy[s]` is low) is captured at the clock edge. `wr_busy[s]` is high from the next cycle and stays high until the message is delivered.
- R3: While `wr_busy[s]` is high, a request is not captured and the held data is not changed. A request held across the delivery cycle is captured in the first cycle in which busy is low, and it is delivered afterwards.
- R4: A pending message from sender s to destination d is delivered only in a cycle where (s + `rot_phase`) mod N_CORES equals d. In that cycle `mem_preempt[s]` is high, and `wr_busy[s]` is low in the next cycle.
- R5: After a delivery from s to d, bit s of destination d's slice of `avail` (bit d*N_CORES+s) is 1. With `rd_src` for d set to s, `rd_data` for d shows the delivered word.
- R6: Each receiver keeps a separate word for each source. A new delivery from a source replaces only that source's word.
- R7: `rd_en[d]` clears availability bit `rd_src` of receiver d at the next edge. If a delivery from that same source lands at the same edge, the bit stays 1 and the new word is stored.
- R8: `irq[d]` is high exactly while some availability bit of d is set whose latest delivery had `wr_irq` high. A delivery with `wr_irq` low does not raise it.
- R9: A write whose destination equals its own sender index is delivered on its aligned slot, like any other write.
- R10: A captured message shows up in `avail` no later than N_CORES+1 cycles after the capture edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_req | input | N_CORES | Per-sender write request, held until accepted |
| wr_dest | input | N_CORES*IDX_W | Per-sender destination index |
| wr_data | input | N_CORES*DATA_W | Per-sender message word |
| wr_irq | input | N_CORES | Per-sender flag: raise the destination interrupt |
| wr_busy | output | N_CORES | Per-sender: a message is pending |
| mem_preempt | output | N_CORES | Per-sender: this cycle's shared-memory slot is used by a message |
| rd_en | input | N_CORES | Per-receiver read strobe, clears the named source's mark |
| rd_src | input | N_CORES*IDX_W | Per-receiver source index to read |
| rd_data | output | N_CORES*DATA_W | Per-receiver word last received from `rd_src` |
| avail | output | N_CORES*N_CORES | Per-receiver availability mask, bit d*N_CORES+s |
| irq | output | N_CORES | Per-receiver interrupt |
| rot_phase | output | IDX_W | Current rotation count |

## Verification
The bench checks the slot in which `mem_preempt` rises against the rotation count. A design that used the wrong alignment, or that delivered as soon as a write was captured, would fail this check. It holds a second write through the first message's delivery. Dropping that write, or replacing the first word before it is sent, would show up in the data read back. It puts a read strobe in the same cycle as a fresh arrival from the same source. A design that gives the clear priority would lose the mark for the new word. It also sends words from two sources to one receiver, and sends a word with its interrupt flag clear. These catch a shared message register and an interrupt that follows availability alone.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  parameter int unsigned CORES_DEF = 16;
  parameter int unsigned WORD_DEF  = 32;
endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_q_n <= meta_q;
    end
  end
endmodule

// File: rtl/mbx_rotor.sv
module mbx_rotor #(
  parameter int unsigned IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [IW-1:0] phase_o
);
  logic [IW-1:0] phase_q, phase_d;

  always_comb begin
    phase_d = phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/mbx_sender.sv
module mbx_sender #(
  parameter int unsigned W  = 32,
  parameter int unsigned IW = 4,
  parameter int unsigned ID = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] phase,
  input  logic          req,
  input  logic [IW-1:0] dest,
  input  logic [W-1:0]  data,
  input  logic          irqf,
  output logic          busy,
  output logic          fire,
  output logic [W-1:0]  pend_data,
  output logic          pend_irq
);
  localparam logic [IW-1:0] MY_IDX = IW'(ID);

  logic          pv_q, pv_d;
  logic          accept;
  logic [IW-1:0] dest_q;
  logic [W-1:0]  data_q;
  logic          irq_q;
  logic [IW-1:0] peer;

  always_comb begin
    peer   = MY_IDX + phase;
    accept = req && !pv_q;
    fire   = pv_q && (dest_q == peer);
    pv_d   = pv_q;
    if (accept)    pv_d = 1'b1;
    else if (fire) pv_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pv_q <= 1'b0;
    else        pv_q <= pv_d;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      dest_q <= dest;
      data_q <= data;
      irq_q  <= irqf;
    end
  end

  assign busy      = pv_q;
  assign pend_data = data_q;
  assign pend_irq  = irq_q;
endmodule

// File: rtl/mbx_receiver.sv
module mbx_receiver #(
  parameter int unsigned N  = 16,
  parameter int unsigned W  = 32,
  parameter int unsigned IW = 4,
  parameter int unsigned ID = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] phase,
  input  logic [N-1:0]  snd_fire,
  input  logic [W-1:0]  snd_data [N],
  input  logic [N-1:0]  snd_irq,
  input  logic          rd_en,
  input  logic [IW-1:0] rd_src,
  output logic [W-1:0]  rd_data,
  output logic [N-1:0]  avail,
  output logic          irq
);
  localparam logic [IW-1:0] MY_IDX = IW'(ID);

  logic [IW-1:0] src;
  logic          hit;
  logic [N-1:0]  avail_q, avail_d;
  logic [N-1:0]  flag_q, flag_d;
  logic [W-1:0]  msg_q [N];

  always_comb begin
    src     = MY_IDX - phase;
    hit     = snd_fire[src];
    avail_d = avail_q;
    flag_d  = flag_q;
    for (int j = 0; j < int'(N); j++) begin
      if (hit && (src == IW'(j))) begin
        avail_d[j] = 1'b1;
        flag_d[j]  = snd_irq[j];
      end else if (rd_en && (rd_src == IW'(j))) begin
        avail_d[j] = 1'b0;
        flag_d[j]  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avail_q <= '0;
      flag_q  <= '0;
    end else begin
      avail_q <= avail_d;
      flag_q  <= flag_d;
    end
  end

  always_ff @(posedge clk) begin
    if (hit) msg_q[src] <= snd_data[src];
  end

  assign rd_data = msg_q[rd_src];
  assign avail   = avail_q;
  assign irq     = |(avail_q & flag_q);
endmodule

// File: rtl/slot_mailbox.sv
module slot_mailbox
  import mbx_pkg::*;
#(
  parameter int unsigned N_CORES = CORES_DEF,
  parameter int unsigned DATA_W  = WORD_DEF,
  localparam int unsigned IDX_W  = $clog2(N_CORES)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_CORES-1:0]         wr_req,
  input  logic [N_CORES*IDX_W-1:0]   wr_dest,
  input  logic [N_CORES*DATA_W-1:0]  wr_data,
  input  logic [N_CORES-1:0]         wr_irq,
  output logic [N_CORES-1:0]         wr_busy,
  output logic [N_CORES-1:0]         mem_preempt,
  input  logic [N_CORES-1:0]         rd_en,
  input  logic [N_CORES*IDX_W-1:0]   rd_src,
  output logic [N_CORES*DATA_W-1:0]  rd_data,
  output logic [N_CORES*N_CORES-1:0] avail,
  output logic [N_CORES-1:0]         irq,
  output logic [IDX_W-1:0]           rot_phase
);
  logic               rst_q_n;
  logic [IDX_W-1:0]   phase;
  logic [N_CORES-1:0] fire;
  logic [N_CORES-1:0] pend_irq;
  logic [DATA_W-1:0]  pend_data [N_CORES];

  mbx_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  mbx_rotor #(.IW(IDX_W)) u_rotor (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .phase_o (phase)
  );

  for (genvar s = 0; s < N_CORES; s++) begin : g_snd
    mbx_sender #(.W(DATA_W), .IW(IDX_W), .ID(s)) u_snd (
      .clk       (clk),
      .rst_n     (rst_q_n),
      .phase     (phase),
      .req       (wr_req[s]),
      .dest      (wr_dest[s*IDX_W +: IDX_W]),
      .data      (wr_data[s*DATA_W +: DATA_W]),
      .irqf      (wr_irq[s]),
      .busy      (wr_busy[s]),
      .fire      (fire[s]),
      .pend_data (pend_data[s]),
      .pend_irq  (pend_irq[s])
    );
  end

  for (genvar r = 0; r < N_CORES; r++) begin : g_rcv
    mbx_receiver #(.N(N_CORES), .W(DATA_W), .IW(IDX_W), .ID(r)) u_rcv (
      .clk      (clk),
      .rst_n    (rst_q_n),
      .phase    (phase),
      .snd_fire (fire),
      .snd_data (pend_data),
      .snd_irq  (pend_irq),
      .rd_en    (rd_en[r]),
      .rd_src   (rd_src[r*IDX_W +: IDX_W]),
      .rd_data  (rd_data[r*DATA_W +: DATA_W]),
      .avail    (avail[r*N_CORES +: N_CORES]),
      .irq      (irq[r])
    );
  end

  assign mem_preempt = fire;
  assign rot_phase   = phase;
endmodule

// File: rtl/mbx_chk.sv
module mbx_chk #(
  parameter int unsigned N  = 16,
  parameter int unsigned IW = 4
) (
  input logic           clk,
  input logic           rst_q_n,
  input logic [IW-1:0]  rot_phase,
  input logic [N-1:0]   wr_req,
  input logic [N-1:0]   wr_busy,
  input logic [N-1:0]   mem_preempt,
  input logic [N*N-1:0] avail,
  input logic [N-1:0]   irq
);
  // R1
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    1'b1 |=> (rot_phase == IW'($past(rot_phase) + 1'b1)));

  for (genvar s = 0; s < N; s++) begin : g_s
    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
      (wr_req[s] && !wr_busy[s]) |=> wr_busy[s]);
    // R3
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
      (wr_busy[s] && !mem_preempt[s]) |=> wr_busy[s]);
    // R4
    preempt_busy_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
      mem_preempt[s] |-> wr_busy[s]);
    // R4
    preempt_release_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
      mem_preempt[s] |=> !wr_busy[s]);
  end

  for (genvar r = 0; r < N; r++) begin : g_r
    // R8
    irq_needs_avail_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
      irq[r] |-> (avail[r*N +: N] != '0));
  end
endmodule

bind slot_mailbox mbx_chk #(.N(N_CORES), .IW(IDX_W)) u_chk (
  .clk         (clk),
  .rst_q_n     (rst_q_n),
  .rot_phase   (rot_phase),
  .wr_req      (wr_req),
  .wr_busy     (wr_busy),
  .mem_preempt (mem_preempt),
  .avail       (avail),
  .irq         (irq)
);

// File: tb/tb_slot_mailbox.sv
`timescale 1ns/1ps
module tb_slot_mailbox;
  localparam int N  = 16;
  localparam int W  = 32;
  localparam int IW = 4;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [N-1:0]   wr_req;
  logic [N*IW-1:0] wr_dest;
  logic [N*W-1:0] wr_data;
  logic [N-1:0]   wr_irq;
  logic [N-1:0]   wr_busy;
  logic [N-1:0]   mem_preempt;
  logic [N-1:0]   rd_en;
  logic [N*IW-1:0] rd_src;
  logic [N*W-1:0] rd_data;
  logic [N*N-1:0] avail;
  logic [N-1:0]   irq;
  logic [IW-1:0]  rot_phase;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  slot_mailbox dut (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_dest(wr_dest),
    .wr_data(wr_data), .wr_irq(wr_irq), .wr_busy(wr_busy),
    .mem_preempt(mem_preempt), .rd_en(rd_en), .rd_src(rd_src),
    .rd_data(rd_data), .avail(avail), .irq(irq), .rot_phase(rot_phase)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic avail_bit(input int d, input int s);
    return avail[d*N + s];
  endfunction

  function automatic logic [W-1:0] read_word(input int d);
    return rd_data[d*W +: W];
  endfunction

  task automatic set_write(input int s, input int d, input logic [W-1:0] v, input bit f);
    wr_dest[s*IW +: IW] = IW'(d);
    wr_data[s*W +: W]   = v;
    wr_irq[s]           = f;
  endtask

  task automatic wait_fire(input int s, input string req, output int lat);
    lat = 1;
    while (!mem_preempt[s] && lat <= N + 2) begin
      @(negedge clk);
      lat++;
    end
  endtask

  // One full message: capture, aligned slot, visible afterwards.
  task automatic post(input int s, input int d, input logic [W-1:0] v, input bit f,
                      input string req);
    int lat;
    @(negedge clk);
    set_write(s, d, v, f);
    wr_req[s] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_req[s] = 1'b0;
    chk(wr_busy[s] == 1'b1, "R2", "busy after capture", 64'(wr_busy[s]), 64'd1);
    wait_fire(s, req, lat);
    chk(mem_preempt[s] && (((s + int'(rot_phase)) % N) == d), req,
        "R4 aligned preempt slot", 64'((s + int'(rot_phase)) % N), 64'(d));
    chk(lat <= N, "R10", "latency cycles", 64'(lat + 1), 64'(N + 1));
    @(negedge clk);
    chk(wr_busy[s] == 1'b0, "R4", "busy after delivery", 64'(wr_busy[s]), 64'd0);
    rd_src[d*IW +: IW] = IW'(s);
    #0.1;
    chk(avail_bit(d, s) == 1'b1, req, "avail bit", 64'(avail_bit(d, s)), 64'd1);
    chk(read_word(d) == v, req, "delivered word", 64'(read_word(d)), 64'(v));
  endtask

  task automatic read_clear(input int d, input int s);
    @(negedge clk);
    rd_en[d] = 1'b1;
    rd_src[d*IW +: IW] = IW'(s);
    @(posedge clk);
    @(negedge clk);
    rd_en[d] = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(rot_phase == '0, "R1", "phase in reset", 64'(rot_phase), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(avail == '0, "R5", "avail after reset", 64'(avail[63:0]), 64'd0);
    chk(irq == '0, "R8", "irq after reset", 64'(irq), 64'd0);
    chk(wr_busy == '0, "R2", "busy after reset", 64'(wr_busy), 64'd0);
  endtask

  task automatic t_rotation;
    bit ok = 1'b1;
    int prev = int'(rot_phase);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (int'(rot_phase) != (prev + 1) % N) ok = 1'b0;
      prev = int'(rot_phase);
    end
    chk(ok, "R1", "phase step", 64'(rot_phase), 64'((prev) % N));
  endtask

  task automatic t_irq;
    post(0, 5, 32'hA5A5_0001, 1'b1, "R5");
    chk(irq[5] == 1'b1, "R8", "irq raised", 64'(irq[5]), 64'd1);
    read_clear(5, 0);
    chk(avail_bit(5, 0) == 1'b0, "R7", "bit cleared by read", 64'(avail_bit(5, 0)), 64'd0);
    chk(irq[5] == 1'b0, "R8", "irq dropped", 64'(irq[5]), 64'd0);
    post(1, 5, 32'h1111_0001, 1'b0, "R8");
    chk(irq[5] == 1'b0, "R8", "no irq when flag clear", 64'(irq[5]), 64'd0);
  endtask

  task automatic t_per_source;
    post(2, 5, 32'h2222_0002, 1'b0, "R6");
    rd_src[5*IW +: IW] = IW'(1);
    #0.1;
    chk(read_word(5) == 32'h1111_0001, "R6", "other source kept",
        64'(read_word(5)), 64'h1111_0001);
    post(1, 5, 32'h1111_0003, 1'b0, "R6");
    rd_src[5*IW +: IW] = IW'(2);
    #0.1;
    chk(read_word(5) == 32'h2222_0002, "R6", "untouched after overwrite",
        64'(read_word(5)), 64'h2222_0002);
  endtask

  task automatic t_self;
    post(7, 7, 32'h7777_7777, 1'b1, "R9");
    chk(irq[7] == 1'b1, "R9", "self irq", 64'(irq[7]), 64'd1);
  endtask

  task automatic t_stall;
    int lat;
    @(negedge clk);
    set_write(3, 9, 32'hAAAA_0003, 1'b0);
    wr_req[3] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    set_write(3, 9, 32'hBBBB_0003, 1'b0);
    wait_fire(3, "R3", lat);
    chk(mem_preempt[3] && (((3 + int'(rot_phase)) % N) == 9), "R3",
        "first slot", 64'(rot_phase), 64'(6));
    @(negedge clk);
    rd_src[9*IW +: IW] = IW'(3);
    #0.1;
    chk(read_word(9) == 32'hAAAA_0003, "R3", "first word not replaced",
        64'(read_word(9)), 64'hAAAA_0003);
    @(negedge clk);
    chk(wr_busy[3] == 1'b1, "R3", "held request captured", 64'(wr_busy[3]), 64'd1);
    wr_req[3] = 1'b0;
    wait_fire(3, "R3", lat);
    @(negedge clk);
    #0.1;
    chk(read_word(9) == 32'hBBBB_0003, "R3", "second word delivered",
        64'(read_word(9)), 64'hBBBB_0003);
  endtask

  task automatic t_collision;
    int lat;
    post(4, 6, 32'h4444_0001, 1'b0, "R7");
    @(negedge clk);
    set_write(4, 6, 32'h4444_0002, 1'b0);
    wr_req[4] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_req[4] = 1'b0;
    wait_fire(4, "R7", lat);
    rd_en[6] = 1'b1;
    rd_src[6*IW +: IW] = IW'(4);
    #0.1;
    chk(read_word(6) == 32'h4444_0001, "R7", "old word during collision",
        64'(read_word(6)), 64'h4444_0001);
    @(posedge clk);
    @(negedge clk);
    rd_en[6] = 1'b0;
    #0.1;
    chk(avail_bit(6, 4) == 1'b1, "R7", "bit kept on collision",
        64'(avail_bit(6, 4)), 64'd1);
    chk(read_word(6) == 32'h4444_0002, "R7", "new word kept",
        64'(read_word(6)), 64'h4444_0002);
  endtask

  initial begin
    #800us;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    wr_req  = '0;
    wr_dest = '0;
    wr_data = '0;
    wr_irq  = '0;
    rd_en   = '0;
    rd_src  = '0;
    repeat (3) @(negedge clk);
    t_reset();
    t_rotation();
    t_irq();
    t_per_source();
    t_self();
    t_stall();
    t_collision();
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule